// File: doc/BRIEF.md
# Embedded Erase Status Reporter

While an embedded erase runs, the host cannot read the memory array. It polls a status byte instead. This block builds that byte and an active-low busy level from phase flags supplied by the erase sequencer. The flags are: sector-add window open, erase running, erase finished, time limit overrun, and a pulse marking an attempt to erase a protected sector. Two of the status bits are toggle bits. They change state each time a read strobe falls, so two back-to-back reads that differ show that the operation is still live.

When no phase flag is set and no protected-sector attempt is pending, the block is in read-array mode. The output bus then carries the array read data unchanged and the busy level is released. A protected-sector attempt makes the toggle bits run for a bounded number of cycles. After that the block falls back to read-array mode and nothing is modified.

Top module: `erase_status_top`

## Requirements
- R1: In read-array mode (no phase flag registered and no protected-attempt timer running), `poll_data` equals `array_rdata` in the same cycle and `ready_o` is 1.
- R2: Bit 7 of the status byte reads 0 in the window, erase, overrun and protected modes, and reads 1 in the finished mode.
- R3: Bits 6 and 2 flip together on every falling edge of `rd_strobe` seen while the mode is window, erase, overrun or protected. A falling edge is `rd_strobe` high at one clock edge and low at the next. The new value is visible from the second of those edges.
- R4: In the finished mode, bit 6 holds the value it had when the toggling stopped, and bit 2 reads 1.
- R5: Bit 5 reads 1 only in the overrun mode, and 0 in every other status mode.
- R6: Bit 3 reads 0 in the window mode. It reads 1 in the erase, overrun, protected and finished modes.
- R7: `ready_o` is 0 in the window, erase, overrun and protected modes. It is 1 in the finished and read-array modes.
- R8: When several causes are present, the mode follows this priority: protected timer running, then overrun, then erase, then window, then finished.
- R9: A `prot_hit` pulse keeps the block in protected mode for exactly `PROT_CYCLES` cycles, starting one cycle after the pulse is sampled. A new pulse restarts the count. The block then returns to read-array mode.
- R10: In every status mode, bits 4, 1 and 0 and all bits above bit 7 read 0.
- R11: The toggle state returns to 0 after any cycle spent in read-array mode, so the first status read of a new operation shows bits 6 and 2 as 0.
- R12: The phase flags are registered, so a change on them shows on the outputs one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_window | input | 1 | Sector-add window open |
| ph_erasing | input | 1 | Erase running |
| ph_finished | input | 1 | Erase completed |
| ph_overtime | input | 1 | Erase exceeded its time limit |
| prot_hit | input | 1 | One-cycle pulse: erase attempted on a protected sector |
| rd_strobe | input | 1 | Host read strobe, active high |
| array_rdata | input | DATA_W | Array read data for read-array mode |
| poll_data | output | DATA_W | Status byte or array data |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
Phase flags and `prot_hit` reach the outputs one clock edge after they are sampled. The toggle bits flip at the edge that samples the strobe low after it was high. The array pass-through is combinational within the same cycle. The bench drives inputs 2 ns after a rising edge. A behavioural model updates on each rising edge from the same inputs, and the outputs are compared at the following falling edge, so each result is checked in the first cycle it is due.

// File: rtl/erase_status_pkg.sv
package erase_status_pkg;

  typedef enum logic [2:0] {
    MD_ARRAY  = 3'd0,
    MD_WINDOW = 3'd1,
    MD_ERASE  = 3'd2,
    MD_FAULT  = 3'd3,
    MD_DONE   = 3'd4,
    MD_PROT   = 3'd5
  } poll_mode_e;

  // Modes in which the toggle bits advance on a read.
  function automatic logic mode_toggles(poll_mode_e m);
    return (m == MD_WINDOW) || (m == MD_ERASE) || (m == MD_FAULT) || (m == MD_PROT);
  endfunction

  // Busy whenever the toggle bits are live.
  function automatic logic mode_busy(poll_mode_e m);
    return mode_toggles(m);
  endfunction

  // Status byte: bit7 completion, bit6/bit2 toggles, bit5 overrun, bit3 started.
  function automatic logic [7:0] status_byte(poll_mode_e m, logic tog);
    logic [7:0] s;
    s    = 8'h00;
    s[7] = (m == MD_DONE);
    s[6] = tog;
    s[5] = (m == MD_FAULT);
    s[3] = (m != MD_WINDOW);
    s[2] = (m == MD_DONE) ? 1'b1 : tog;
    return s;
  endfunction

endpackage

// File: rtl/erase_phase_decode.sv
module erase_phase_decode
  import erase_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph_window,
  input  logic       ph_erasing,
  input  logic       ph_finished,
  input  logic       ph_overtime,
  input  logic       prot_active,
  output poll_mode_e mode
);

  logic win_q, ers_q, fin_q, ovt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      ers_q <= 1'b0;
      fin_q <= 1'b0;
      ovt_q <= 1'b0;
    end else begin
      win_q <= ph_window;
      ers_q <= ph_erasing;
      fin_q <= ph_finished;
      ovt_q <= ph_overtime;
    end
  end

  // Priority order is part of the behaviour (R8).
  always_comb begin
    if (prot_active)  mode = MD_PROT;
    else if (ovt_q)   mode = MD_FAULT;
    else if (ers_q)   mode = MD_ERASE;
    else if (win_q)   mode = MD_WINDOW;
    else if (fin_q)   mode = MD_DONE;
    else              mode = MD_ARRAY;
  end

  // R12: a fault mode can only follow a sampled overtime flag.
  assert_fault_follows_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FAULT) |-> $past(ph_overtime));

  // R8: the window mode never hides a running erase.
  assert_window_below_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WINDOW) |-> !$past(ph_erasing));

endmodule

// File: rtl/erase_prot_timer.sv
module erase_prot_timer #(
  parameter int PROT_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_hit,
  output logic prot_active
);

  localparam int CNT_W = $clog2(PROT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (prot_hit)       cnt_q <= CNT_W'(PROT_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign prot_active = (cnt_q != '0);

  // R9: the count never exceeds the configured bound.
  assert_prot_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PROT_CYCLES));

  // R9: a pulse always opens the protected window on the next cycle.
  assert_prot_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> prot_active);

endmodule

// File: rtl/erase_toggle_gen.sv
module erase_toggle_gen
  import erase_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_strobe,
  input  poll_mode_e mode,
  output logic       tog,
  output logic       rd_fall_live
);

  logic rd_q;
  logic clear_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_strobe;
  end

  assign rd_fall_live = rd_q && !rd_strobe && mode_toggles(mode);
  assign clear_evt    = (mode == MD_ARRAY);

  always_ff @(posedge clk) begin
    if (!rst_n)            tog <= 1'b0;
    else if (clear_evt)    tog <= 1'b0;
    else if (rd_fall_live) tog <= ~tog;
  end

  // R3: the toggle moves only after a live strobe fall or a clear.
  assert_toggle_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tog != $past(tog)) |-> ($past(rd_fall_live) || $past(clear_evt)));

  // R4: the toggle is frozen in the finished mode.
  assert_toggle_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MD_DONE) |-> $stable(tog));

endmodule

// File: rtl/erase_status_top.sv
module erase_status_top
  import erase_status_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PROT_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_window,
  input  logic              ph_erasing,
  input  logic              ph_finished,
  input  logic              ph_overtime,
  input  logic              prot_hit,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] poll_data,
  output logic              ready_o
);

  poll_mode_e mode;
  logic       prot_active;
  logic       tog;
  logic       rd_fall_live;
  logic [7:0] stat;

  erase_prot_timer #(.PROT_CYCLES(PROT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .prot_hit   (prot_hit),
    .prot_active(prot_active)
  );

  erase_phase_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph_window  (ph_window),
    .ph_erasing (ph_erasing),
    .ph_finished(ph_finished),
    .ph_overtime(ph_overtime),
    .prot_active(prot_active),
    .mode       (mode)
  );

  erase_toggle_gen u_toggle (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .mode        (mode),
    .tog         (tog),
    .rd_fall_live(rd_fall_live)
  );

  assign stat      = status_byte(mode, tog);
  assign poll_data = (mode == MD_ARRAY) ? array_rdata : DATA_W'(stat);
  assign ready_o   = !mode_busy(mode);

  // R1: read-array mode passes the array word straight through.
  assert_array_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ARRAY) |-> (poll_data == array_rdata && ready_o));

  // R7: busy is never shown together with the completion bit.
  assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_ARRAY && poll_data[7]) |-> ready_o);

  // R5: the overrun bit appears only while the block is busy.
  assert_overrun_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_ARRAY && poll_data[5]) |-> !ready_o);

  // R10: unused status bits stay clear.
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_ARRAY) |-> (poll_data[4] == 1'b0 && poll_data[1:0] == 2'b00));

endmodule

// File: tb/erase_status_top_tb.sv
module erase_status_top_tb;

  localparam int DW = 8;
  localparam int PC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph_window = 0, ph_erasing = 0, ph_finished = 0, ph_overtime = 0;
  logic prot_hit = 0, rd_strobe = 0;
  logic [DW-1:0] array_rdata = 8'h00;
  logic [DW-1:0] poll_data;
  logic ready_o;

  int checks = 0;
  int errors = 0;
  string scen = "R1";
  bit done_flag = 0;

  always #4 clk = ~clk;

  erase_status_top #(.DATA_W(DW), .PROT_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ph_window(ph_window), .ph_erasing(ph_erasing),
    .ph_finished(ph_finished), .ph_overtime(ph_overtime),
    .prot_hit(prot_hit), .rd_strobe(rd_strobe),
    .array_rdata(array_rdata), .poll_data(poll_data), .ready_o(ready_o)
  );

  // Reference model: 0 array, 1 window, 2 erase, 3 overrun, 4 finished, 5 protected.
  int m_w = 0, m_e = 0, m_f = 0, m_o = 0;
  int m_cnt = 0;
  int m_tog = 0;
  int m_rd = 0;

  function automatic int ref_mode();
    if (m_cnt > 0) return 5;
    if (m_o) return 3;
    if (m_e) return 2;
    if (m_w) return 1;
    if (m_f) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    int md;
    md = ref_mode();
    if (!rst_n) begin
      m_w = 0; m_e = 0; m_f = 0; m_o = 0; m_cnt = 0; m_tog = 0; m_rd = 0;
    end else begin
      if (md == 0) m_tog = 0;
      else if (md != 4 && m_rd == 1 && rd_strobe == 0) m_tog = 1 - m_tog;
      m_rd = rd_strobe;
      if (prot_hit) m_cnt = PC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_w = ph_window; m_e = ph_erasing; m_f = ph_finished; m_o = ph_overtime;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t: actual %0h expected %0h", req, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int md;
    md = ref_mode();
    if (!done_flag) begin
      if (md == 0) begin
        chk("R1 data", poll_data, array_rdata);
        chk("R1 ready", ready_o, 1);
      end else begin
        chk("R2 bit7", poll_data[7], md == 4);
        chk("R3/R4 bit6", poll_data[6], m_tog);
        chk("R5 bit5", poll_data[5], md == 3);
        chk("R6 bit3", poll_data[3], md != 1);
        chk("R3/R4 bit2", poll_data[2], (md == 4) ? 1 : m_tog);
        chk("R10 unused", {poll_data[4], poll_data[1:0]}, 0);
        chk("R7 ready", ready_o, (md == 4) ? 1 : 0);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic do_read();
    rd_strobe = 1; cyc(2);
    rd_strobe = 0; cyc(2);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    scen = "R1 reset";
    array_rdata = 8'h5A; cyc(1);
    rst_n = 1; cyc(1);
    scen = "R1 pass";
    for (int i = 0; i < 6; i++) begin array_rdata = 8'(i * 37 + 1); cyc(1); end

    scen = "R12 window";
    ph_window = 1; cyc(1);
    scen = "R3 window";
    for (int i = 0; i < 3; i++) do_read();
    scen = "R6 erase";
    ph_window = 0; ph_erasing = 1; cyc(1);
    for (int i = 0; i < 3; i++) do_read();
    scen = "R5 overrun";
    ph_overtime = 1; cyc(1);
    do_read(); do_read();
    scen = "R8 overrun over erase";
    ph_window = 1; cyc(2);
    scen = "R4 finished";
    ph_overtime = 0; ph_erasing = 0; ph_window = 0; ph_finished = 1; cyc(1);
    do_read(); do_read();
    scen = "R11 back to array";
    ph_finished = 0; array_rdata = 8'hC3; cyc(2);
    ph_window = 1; cyc(1); do_read();
    scen = "R11 clear";
    ph_window = 0; cyc(2);

    scen = "R9 protected";
    prot_hit = 1; cyc(1); prot_hit = 0;
    for (int i = 0; i < 4; i++) do_read();
    cyc(8);
    scen = "R9 restart";
    prot_hit = 1; cyc(1); prot_hit = 0;
    scen = "R8 prot over overrun";
    ph_overtime = 1; cyc(1);
    for (int i = 0; i < 6; i++) do_read();
    ph_overtime = 0; array_rdata = 8'h3C; cyc(4);
    scen = "R9 expiry";
    cyc(PC);
    scen = "R1 final";
    array_rdata = 8'hFF; cyc(2);
    scen = "R10 finished unused";
    ph_finished = 1; cyc(2); ph_finished = 0; cyc(2);
    finish_run();
  end

endmodule